// File: doc/BRIEF.md
# Folded Torus Route Generator

This block turns a destination tile address into a source route for a 4x4 folded torus. The ring in each row and in each column links its four nodes in the cyclic order 0, 2, 3, 1. The coordinate a client gives is therefore not its place on the ring. The block first maps each coordinate to its position along the ring. It then finds the shorter way around the X ring and the shorter way around the Y ring. From these two legs it builds a 16-bit word of 2-bit hop codes. Each code is a relative instruction to the router that reads it: go straight, turn left, turn right, or deliver the packet locally (extract).

The route always covers the X ring first. It then turns onto the Y ring and ends with an extract code. A client samples its own coordinates and the destination coordinates together with a request strobe. One cycle later the route appears on the registered output, together with a valid flag. The route word keeps its value until the next request.

The router at the source has no travel heading. So the first code has a special meaning there: right leaves along the positive X ring direction, left leaves along the negative one, and straight means "no X leg; take +X as the reference heading for the turn that follows."

Top module: `ftr_route_gen`

## Requirements
- R1: A coordinate's position on its ring follows the link order 0,2,3,1. Node 0 is at position 0, node 2 at 1, node 3 at 2 and node 1 at 3. Moving from position p to position p+1 (mod 4) is one hop in the positive direction.
- R2: Each ring leg takes the shorter way around. When the two ways are equal (two hops), the positive direction is used, so a leg is never longer than two hops.
- R3: The hop codes are straight=00, left=01, right=10 and extract=11. Hop k sits in route bits [2k+1:2k], so hop 0 is in bits [1:0].
- R4: When the X coordinates differ, hop 0 is right for a positive X leg or left for a negative X leg. One straight code follows for each further X hop, and only after that do any Y codes appear.
- R5: When both legs are non-empty, the code right after the X leg is a turn relative to the X heading. Heading +X: +Y is left and -Y is right. Heading -X: +Y is right and -Y is left. One straight code follows for each further Y hop.
- R6: An extract code follows the last move. Every hop slot above it holds extract, so the top slot (bits [15:14]) is always extract.
- R7: When the destination equals the local tile, the route is 16'hFFFF, a single extract at hop 0 with every other slot also extract.
- R8: valid_o is high in exactly the cycle after a cycle in which req_i was high. route_o changes only in that cycle and holds its value while req_i is low.
- R9: While reset is asserted and until the first request after reset, valid_o is 0 and route_o is 16'h0000.
- R10: When only the Y coordinates differ, hop 0 is straight and hop 1 is the turn taken relative to a +X heading (left for +Y, right for -Y).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Translate request; coordinates are sampled with it |
| src_x_i | input | 2 | Local tile column |
| src_y_i | input | 2 | Local tile row |
| dst_x_i | input | 2 | Destination tile column |
| dst_y_i | input | 2 | Destination tile row |
| route_o | output | 16 | Registered route word, hop 0 in bits [1:0] |
| valid_o | output | 1 | High for one cycle when route_o holds a new route |

## Verification
The hardest cases to reach from the ports are the ones where ring order and numeric order disagree. These are the two-hop tie, where the shorter-way choice is ambiguous, and a negative X leg followed by a Y leg, where the turn sense reverses. The bench drives every one of the 256 source and destination pairs. A simple numeric-distance mistake therefore cannot hide behind lucky coordinates. Requests are spaced with idle cycles between them, so the hold behaviour is tested with a live route on the output. Hand-worked routes for the tie, the reversed turn and the longest route are checked against fixed words as well.

// File: rtl/ftr_pkg.sv
package ftr_pkg;

  localparam int RING_NODES = 4;
  localparam int COORD_W    = 2;
  localparam int HOP_W      = 2;

  typedef enum logic [HOP_W-1:0] {
    HOP_STRAIGHT = 2'b00,
    HOP_LEFT     = 2'b01,
    HOP_RIGHT    = 2'b10,
    HOP_EXTRACT  = 2'b11
  } hop_code_e;

  typedef struct packed {
    logic               fwd;
    logic [COORD_W-1:0] count;
  } ring_leg_t;

  // position of a node along a ring linked in the order 0,2,3,1
  function automatic logic [COORD_W-1:0] ring_slot(input logic [COORD_W-1:0] node);
    logic [COORD_W-1:0] slot;
    case (node)
      2'd0:    slot = 2'd0;
      2'd2:    slot = 2'd1;
      2'd3:    slot = 2'd2;
      default: slot = 2'd3;
    endcase
    return slot;
  endfunction

endpackage

// File: rtl/ftr_rst_sync.sv
module ftr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;

endmodule

// File: rtl/ftr_ring_leg.sv
module ftr_ring_leg
  import ftr_pkg::*;
(
  input  logic [COORD_W-1:0] here_i,
  input  logic [COORD_W-1:0] there_i,
  output ring_leg_t          leg_o
);

  localparam logic [COORD_W-1:0] HALF = COORD_W'(RING_NODES / 2);

  logic [COORD_W-1:0] pos_here;
  logic [COORD_W-1:0] pos_there;
  logic [COORD_W-1:0] gap;

  always_comb begin
    pos_here  = ring_slot(here_i);
    pos_there = ring_slot(there_i);
    gap       = pos_there - pos_here;
    if (gap <= HALF) begin
      // ties (gap == HALF) resolve toward the positive direction
      leg_o.fwd   = 1'b1;
      leg_o.count = gap;
    end else begin
      leg_o.fwd   = 1'b0;
      leg_o.count = ~gap + 1'b1;
    end
  end

endmodule

// File: rtl/ftr_route_pack.sv
module ftr_route_pack
  import ftr_pkg::*;
#(
  parameter int ROUTE_W = 16
) (
  input  ring_leg_t          x_leg_i,
  input  ring_leg_t          y_leg_i,
  output logic [ROUTE_W-1:0] route_o
);

  localparam int SLOTS = ROUTE_W / HOP_W;
  localparam int IDX_W = $clog2(SLOTS) + 2;

  logic             x_moves;
  logic             y_moves;
  logic             head_fwd;
  logic             turn_left;
  logic [IDX_W-1:0] x_len;
  logic [IDX_W-1:0] turn_slot;
  logic [IDX_W-1:0] y_end;
  hop_code_e        turn_code;

  always_comb begin
    x_moves   = |x_leg_i.count;
    y_moves   = |y_leg_i.count;
    head_fwd  = x_moves ? x_leg_i.fwd : 1'b1;
    turn_left = (y_leg_i.fwd == head_fwd);
    turn_code = turn_left ? HOP_LEFT : HOP_RIGHT;
    x_len     = IDX_W'(x_leg_i.count);
    turn_slot = x_moves ? x_len : IDX_W'(1);
    y_end     = turn_slot + IDX_W'(y_leg_i.count);
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam logic [IDX_W-1:0] IDX = IDX_W'(s);
    hop_code_e code;

    if (s == 0) begin : g_head
      always_comb begin
        if (x_moves)      code = x_leg_i.fwd ? HOP_RIGHT : HOP_LEFT;
        else if (y_moves) code = HOP_STRAIGHT;
        else              code = HOP_EXTRACT;
      end
    end else begin : g_body
      always_comb begin
        if (IDX < x_len)                                  code = HOP_STRAIGHT;
        else if (y_moves && IDX == turn_slot)             code = turn_code;
        else if (y_moves && IDX > turn_slot && IDX < y_end) code = HOP_STRAIGHT;
        else                                              code = HOP_EXTRACT;
      end
    end

    assign route_o[s*HOP_W +: HOP_W] = code;
  end

endmodule

// File: rtl/ftr_route_gen.sv
module ftr_route_gen
  import ftr_pkg::*;
#(
  parameter int ROUTE_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_i,
  input  logic [COORD_W-1:0] src_x_i,
  input  logic [COORD_W-1:0] src_y_i,
  input  logic [COORD_W-1:0] dst_x_i,
  input  logic [COORD_W-1:0] dst_y_i,
  output logic [ROUTE_W-1:0] route_o,
  output logic               valid_o
);

  localparam int            AXES = 2;
  localparam logic [COORD_W-1:0] HALF = COORD_W'(RING_NODES / 2);

  logic rst_sync_n;

  ftr_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  logic [COORD_W-1:0] here  [AXES];
  logic [COORD_W-1:0] there [AXES];
  ring_leg_t          legs  [AXES];

  assign here[0]  = src_x_i;
  assign here[1]  = src_y_i;
  assign there[0] = dst_x_i;
  assign there[1] = dst_y_i;

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    ftr_ring_leg u_leg (
      .here_i  (here[a]),
      .there_i (there[a]),
      .leg_o   (legs[a])
    );
  end

  logic [ROUTE_W-1:0] route_c;

  ftr_route_pack #(.ROUTE_W(ROUTE_W)) u_pack (
    .x_leg_i (legs[0]),
    .y_leg_i (legs[1]),
    .route_o (route_c)
  );

  logic [ROUTE_W-1:0] route_d, route_q;
  logic               valid_d, valid_q;
  logic               route_en;

  always_comb begin
    route_en = req_i;
    valid_d  = req_i;
    route_d  = route_en ? route_c : route_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      route_q <= '0;
      valid_q <= 1'b0;
    end else begin
      route_q <= route_d;
      valid_q <= valid_d;
    end
  end

  assign route_o = route_q;
  assign valid_o = valid_q;

  a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |=> valid_o);

  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> !valid_o);

  a_r8_route_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_i |=> $stable(route_o));

  a_r6_top_slot_extract: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |-> route_o[ROUTE_W-1 -: HOP_W] == HOP_EXTRACT);

  a_r7_local_all_extract: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && src_x_i == dst_x_i && src_y_i == dst_y_i) |=> route_o == '1);

  a_r2_leg_short: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_i |-> (legs[0].count <= HALF && legs[1].count <= HALF));

  a_r4_first_hop_x: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && src_x_i != dst_x_i) |=>
      (route_o[HOP_W-1:0] == HOP_LEFT || route_o[HOP_W-1:0] == HOP_RIGHT));

  a_r10_first_hop_y: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && src_x_i == dst_x_i && src_y_i != dst_y_i) |=>
      route_o[HOP_W-1:0] == HOP_STRAIGHT);

endmodule

// File: tb/tb_ftr_route_gen.sv
`timescale 1ns/100ps
module tb_ftr_route_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [1:0]  sx, sy, dx, dy;
  logic [15:0] route;
  logic        valid;

  int checks = 0;
  int errors = 0;

  logic [15:0] exp_route;
  logic        exp_valid;
  string       exp_tag;

  always #2.5 clk = ~clk;

  ftr_route_gen dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req),
    .src_x_i (sx),
    .src_y_i (sy),
    .dst_x_i (dx),
    .dst_y_i (dy),
    .route_o (route),
    .valid_o (valid)
  );

  function automatic int ring_pos(int n);
    int order[4] = '{0, 2, 3, 1};
    int p = 0;
    for (int i = 0; i < 4; i++) if (order[i] == n) p = i;
    return p;
  endfunction

  function automatic void leg(int a, int b, output int n, output int dir);
    int d = (ring_pos(b) - ring_pos(a) + 4) % 4;
    if (d <= 2) begin n = d; dir = 1; end
    else begin n = 4 - d; dir = -1; end
  endfunction

  function automatic logic [15:0] ref_route(int x0, int y0, int x1, int y1);
    int q[$];
    int nx, ny, ddx, ddy, hx;
    logic [15:0] r;
    leg(x0, x1, nx, ddx);
    leg(y0, y1, ny, ddy);
    hx = 1;
    if (nx > 0) begin
      q.push_back(ddx > 0 ? 2 : 1);
      repeat (nx - 1) q.push_back(0);
      hx = ddx;
    end else if (ny > 0) begin
      q.push_back(0);
    end
    if (ny > 0) begin
      q.push_back(ddy == hx ? 1 : 2);
      repeat (ny - 1) q.push_back(0);
    end
    q.push_back(3);
    r = '1;
    foreach (q[i]) r[2*i +: 2] = 2'(q[i]);
    return r;
  endfunction

  function automatic string case_tag(int x0, int y0, int x1, int y1);
    int nx, ny, ddx, ddy;
    leg(x0, x1, nx, ddx);
    leg(y0, y1, ny, ddy);
    if (nx == 0 && ny == 0) return "R7";
    if (nx == 0)            return "R10";
    if (ny == 0)            return "R2";
    return "R5";
  endfunction

  task automatic check16(string tag, logic [15:0] act, logic [15:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: route actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic check1(string tag, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: valid actual %b expected %b", tag, act, expv);
    end
  endtask

  // called at a falling edge: compare, drive, update expectation, advance
  task automatic step(logic r, int x0, int y0, int x1, int y1);
    check1("R8", valid, exp_valid);
    check16(exp_tag, route, exp_route);
    req = r; sx = 2'(x0); sy = 2'(y0); dx = 2'(x1); dy = 2'(y1);
    exp_valid = r;
    if (r) begin
      exp_route = ref_route(x0, y0, x1, y1);
      exp_tag   = case_tag(x0, y0, x1, y1);
    end else begin
      exp_tag = "R8";
    end
    @(negedge clk);
  endtask

  task automatic directed(string tag, int x0, int y0, int x1, int y1, logic [15:0] word);
    step(1'b1, x0, y0, x1, y1);
    check16(tag, route, word);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; sx = '0; sy = '0; dx = '0; dy = '0;
    exp_route = '0; exp_valid = 1'b0; exp_tag = "R9";
    repeat (3) @(negedge clk);
    check1("R9", valid, 1'b0);
    check16("R9", route, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check1("R9", valid, 1'b0);
    check16("R9", route, 16'h0000);

    directed("R3",  0, 0, 2, 0, 16'hFFFE);
    directed("R1",  2, 1, 3, 1, 16'hFFFE);
    directed("R2",  0, 0, 1, 0, 16'hFFFD);
    directed("R2",  0, 0, 3, 0, 16'hFFF2);
    directed("R10", 0, 0, 0, 2, 16'hFFF4);
    directed("R5",  0, 0, 1, 2, 16'hFFF9);
    directed("R4",  0, 0, 3, 3, 16'hFF12);
    directed("R6",  0, 0, 3, 3, 16'hFF12);
    directed("R7",  3, 2, 3, 2, 16'hFFFF);
    step(1'b0, 1, 1, 2, 2);
    check16("R8", route, 16'hFFFF);

    for (int k = 0; k < 256; k++) begin
      step(1'b1, (k >> 6) & 3, (k >> 4) & 3, (k >> 2) & 3, k & 3);
      if (k % 3 == 2) step(1'b0, k & 3, (k >> 2) & 3, 0, 1);
    end
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule